// File: doc/BRIEF.md
# Multi-Context Configuration Register Bank

This block keeps several complete configuration words for a small fabric of 4-input lookup tables on chip. Exactly one of them is live at a time and drives the fabric through a multiplexer. A configuration port writes any stored context, addressed by index, while a different context stays live. A select input moves the fabric to another stored context in a single clock edge, and a fallback input goes back to the context that was live before.

Each context is 64 bits wide: four 16-bit truth tables, one for each LUT. LUT i reads its four user inputs as an index into its own table. The host can therefore preload the next configuration into an idle slot, switch to it in one cycle, and go back to the previous one if the new configuration misbehaves.

Top module: `ctx_cfg_bank`

## Requirements
- R1: After reset the live index is 0, every stored context is all zeros, `cfg_o` and `lut_o` are 0 and `wr_err_o` is 0.
- R2: A write whose index differs from the live index stores `wr_data_i` in that slot. The stored word appears on `cfg_o` once that slot is selected.
- R3: A write to a slot that is not live leaves `cfg_o` and `act_idx_o` unchanged.
- R4: A switch request (`sw_en_i`) to an index other than the live one, with no fallback and no pending switch, sets `act_idx_o` to `sw_idx_i` and puts that slot's word on `cfg_o` right after the next rising edge. The slot that was live becomes the previous slot.
- R5: A write to the live slot is rejected and the stored word stays unchanged. `wr_err_o` is 1 for exactly the one cycle after the edge that sampled the write.
- R6: Fallback (`fb_i`) swaps the live and previous indices at the next edge. Repeated fallbacks therefore toggle between the two slots.
- R7: If a switch and an accepted write name the same index in the same cycle, the write is stored first. The switch then takes effect one edge later, and `cfg_o` shows the newly written word.
- R8: A switch to the index that is already live does nothing. When fallback and switch are requested in the same cycle, fallback wins and the switch is dropped.
- R9: `lut_o[i]` equals `cfg_o[16*i + s]`, where s is `lut_in_i[4*i+3:4*i]` read as an unsigned number.
- R10: In the cycle where a delayed switch is applied, any new switch or fallback request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the configuration port |
| wr_idx_i | input | 2 | Slot index to write |
| wr_data_i | input | 64 | Configuration word to store |
| sw_en_i | input | 1 | Switch request |
| sw_idx_i | input | 2 | Slot to make live |
| fb_i | input | 1 | Fall back to the previous live slot |
| lut_in_i | input | 16 | Four LUT input nibbles, LUT i in bits 4i+3:4i |
| act_idx_o | output | 2 | Live slot index |
| cfg_o | output | 64 | Live configuration word |
| lut_o | output | 4 | LUT outputs |
| wr_err_o | output | 1 | One-cycle pulse for a rejected write |

## Verification
The bench writes to the live slot and then checks the stored word and the error pulse. A design that accepted the write would corrupt the running fabric, and one that held the flag would signal errors that never happened. It raises a write and a switch to the same slot in one cycle. A design without the one-cycle delay would go live with the stale word, and one that never released the pending switch would stay on the old slot. It also covers fallback together with a switch, fallback repeated, and requests that arrive while a delayed switch is being applied. A design with the wrong priority or without the swap of live and previous would land on the wrong slot. Finally, the bench sweeps every LUT input value, which exposes a slice or bit-order mistake in the table lookup.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {
    SEL_HOLD,
    SEL_SWITCH,
    SEL_BACK,
    SEL_APPLY
  } sel_op_e;
endpackage

// File: rtl/ctx_store.sv
module ctx_store #(
  parameter int N_CTX = 4,
  parameter int CFG_W = 64,
  localparam int IDX_W = $clog2(N_CTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CFG_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] act_idx_i,
  output logic [CFG_W-1:0] rd_data_o,
  output logic             wr_err_o
);
  logic [CFG_W-1:0] slot_q [N_CTX];
  logic wr_ok;

  assign wr_ok = wr_en_i && (wr_idx_i != act_idx_i);

  for (genvar k = 0; k < N_CTX; k++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q[k] <= '0;
      else if (wr_ok && wr_idx_i == IDX_W'(k))        slot_q[k] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < N_CTX; k++)
      if (act_idx_i == IDX_W'(k)) rd_data_o = slot_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_err_o <= 1'b0;
    else         wr_err_o <= wr_en_i && !wr_ok;
  end

  // R3
  bg_write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i != act_idx_i) |=>
      (act_idx_i != $past(act_idx_i)) || $stable(rd_data_o));

  // R5
  live_write_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == act_idx_i) |=> wr_err_o);

  // R5
  live_write_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == act_idx_i) |=>
      (act_idx_i != $past(act_idx_i)) || $stable(rd_data_o));
endmodule

// File: rtl/ctx_select.sv
module ctx_select #(
  parameter int N_CTX = 4,
  localparam int IDX_W = $clog2(N_CTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_en_i,
  input  logic [IDX_W-1:0] sw_idx_i,
  input  logic             fb_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic [IDX_W-1:0] act_idx_o
);
  import ctx_pkg::*;

  logic [IDX_W-1:0] act_q, prev_q, pend_idx_q;
  logic             pend_q;
  logic             clash;
  sel_op_e          op;

  // write wins over a switch to the same slot; switch slips one cycle
  assign clash = wr_en_i && (wr_idx_i == sw_idx_i);

  always_comb begin
    if (pend_q)                              op = SEL_APPLY;
    else if (fb_i)                           op = SEL_BACK;
    else if (sw_en_i && sw_idx_i != act_q)   op = SEL_SWITCH;
    else                                     op = SEL_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q      <= '0;
      prev_q     <= '0;
      pend_idx_q <= '0;
      pend_q     <= 1'b0;
    end else begin
      unique case (op)
        SEL_APPLY: begin
          prev_q <= act_q;
          act_q  <= pend_idx_q;
          pend_q <= 1'b0;
        end
        SEL_BACK: begin
          prev_q <= act_q;
          act_q  <= prev_q;
        end
        SEL_SWITCH: begin
          if (clash) begin
            pend_q     <= 1'b1;
            pend_idx_q <= sw_idx_i;
          end else begin
            prev_q <= act_q;
            act_q  <= sw_idx_i;
          end
        end
        default: ;
      endcase
    end
  end

  assign act_idx_o = act_q;

  // R4
  switch_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_i && !fb_i && !pend_q && !clash) |=> act_q == $past(sw_idx_i));

  // R6
  fallback_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_i && !pend_q) |=> (act_q == $past(prev_q)) && (prev_q == $past(act_q)));

  // R7
  clash_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_i && !fb_i && !pend_q && clash && sw_idx_i != act_q) |=> $stable(act_q) && pend_q);

  // R10
  pend_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> (act_q == $past(pend_idx_q)) && !pend_q);
endmodule

// File: rtl/lut_array.sv
module lut_array #(
  parameter int LUT_NUM = 4,
  parameter int LUT_K   = 4,
  localparam int TBL_W  = 1 << LUT_K,
  localparam int CFG_W  = LUT_NUM * TBL_W
) (
  input  logic [CFG_W-1:0]         cfg_i,
  input  logic [LUT_NUM*LUT_K-1:0] sel_i,
  output logic [LUT_NUM-1:0]       out_o
);
  for (genvar i = 0; i < LUT_NUM; i++) begin : g_lut
    logic [TBL_W-1:0] tbl;
    logic [LUT_K-1:0] s;
    assign tbl      = cfg_i[i*TBL_W +: TBL_W];
    assign s        = sel_i[i*LUT_K +: LUT_K];
    assign out_o[i] = tbl[s];
  end
endmodule

// File: rtl/ctx_cfg_bank.sv
module ctx_cfg_bank #(
  parameter int N_CTX   = 4,
  parameter int LUT_NUM = 4,
  parameter int LUT_K   = 4,
  localparam int IDX_W  = $clog2(N_CTX),
  localparam int TBL_W  = 1 << LUT_K,
  localparam int CFG_W  = LUT_NUM * TBL_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [CFG_W-1:0]         wr_data_i,
  input  logic                     sw_en_i,
  input  logic [IDX_W-1:0]         sw_idx_i,
  input  logic                     fb_i,
  input  logic [LUT_NUM*LUT_K-1:0] lut_in_i,
  output logic [IDX_W-1:0]         act_idx_o,
  output logic [CFG_W-1:0]         cfg_o,
  output logic [LUT_NUM-1:0]       lut_o,
  output logic                     wr_err_o
);
  logic [IDX_W-1:0] act_idx;
  logic [CFG_W-1:0] cfg;

  ctx_select #(.N_CTX(N_CTX)) u_sel (
    .clk_i, .rst_ni, .sw_en_i, .sw_idx_i, .fb_i, .wr_en_i, .wr_idx_i,
    .act_idx_o(act_idx)
  );

  ctx_store #(.N_CTX(N_CTX), .CFG_W(CFG_W)) u_store (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i,
    .act_idx_i(act_idx), .rd_data_o(cfg), .wr_err_o
  );

  lut_array #(.LUT_NUM(LUT_NUM), .LUT_K(LUT_K)) u_lut (
    .cfg_i(cfg), .sel_i(lut_in_i), .out_o(lut_o)
  );

  assign act_idx_o = act_idx;
  assign cfg_o     = cfg;

  // R5
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_err_o && !(wr_en_i && wr_idx_i == act_idx)) |=> !wr_err_o);
endmodule

// File: tb/sim_ctx_cfg_bank.sv
module sim_ctx_cfg_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_idx_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        sw_en_i = 1'b0;
  logic [1:0]  sw_idx_i = '0;
  logic        fb_i = 1'b0;
  logic [15:0] lut_in_i = '0;
  logic [1:0]  act_idx_o;
  logic [63:0] cfg_o;
  logic [3:0]  lut_o;
  logic        wr_err_o;

  always #5 clk_i = ~clk_i;

  ctx_cfg_bank u0 (.*);

  typedef struct {
    logic [1:0]  act;
    logic [63:0] cfg;
    logic        err;
    logic [3:0]  lut;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_err = 0;

  // independent reference state
  logic [63:0] m_mem [4];
  logic [1:0]  m_act, m_prev, m_pidx;
  logic        m_pend;

  function automatic logic [3:0] lut_of(logic [63:0] c, logic [15:0] s);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = c[16*i + int'(s[4*i +: 4])];
    return r;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic we, logic [1:0] wi, logic [63:0] wd,
                      logic se, logic [1:0] si, logic fb,
                      logic [15:0] lin, string tag);
    logic acc;
    exp_t e;
    @(negedge clk_i); #1;
    wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
    sw_en_i = se; sw_idx_i = si; fb_i = fb; lut_in_i = lin;
    acc = we && (wi != m_act);
    e.err = we && !acc;
    if (m_pend) begin
      m_prev = m_act; m_act = m_pidx; m_pend = 1'b0;
    end else if (fb) begin
      {m_act, m_prev} = {m_prev, m_act};
    end else if (se && si != m_act) begin
      if (we && wi == si) begin m_pend = 1'b1; m_pidx = si; end
      else begin m_prev = m_act; m_act = si; end
    end
    if (acc) m_mem[wi] = wd;
    @(posedge clk_i);
    e.act = m_act; e.cfg = m_mem[m_act]; e.lut = lut_of(m_mem[m_act], lin); e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "act_idx", 64'(act_idx_o), 64'(e.act));
      check(e.tag, "cfg", cfg_o, e.cfg);
      check(e.tag, "wr_err", 64'(wr_err_o), 64'(e.err));
      check(e.tag, "lut(R9)", 64'(lut_o), 64'(e.lut));
    end
  end

  localparam logic [63:0] DA = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] DB = 64'hFEDC_BA98_7654_3210;
  localparam logic [63:0] DC = 64'hA5A5_5A5A_F00F_0FF0;
  localparam logic [63:0] DD = 64'h8001_7FFE_1234_CAFE;
  localparam logic [63:0] DE = 64'h0F0F_3C3C_6666_AAAA;
  localparam logic [63:0] DX = 64'hDEAD_BEEF_DEAD_BEEF;

  initial begin
    for (int k = 0; k < 4; k++) m_mem[k] = '0;
    m_act = '0; m_prev = '0; m_pidx = '0; m_pend = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    check("R1", "act_idx", 64'(act_idx_o), 64'd0);
    check("R1", "cfg", cfg_o, 64'd0);
    check("R1", "wr_err", 64'(wr_err_o), 64'd0);
    check("R1", "lut", 64'(lut_o), 64'd0);
    rst_ni = 1'b1;

    step(1, 2'd1, DA, 0, 0, 0, 16'hFFFF, "R3");
    step(1, 2'd2, DB, 0, 0, 0, 16'h1234, "R3");
    step(1, 2'd3, DC, 0, 0, 0, 16'h0000, "R3");
    step(0, 0, 0, 1, 2'd1, 0, 16'h8421, "R4");          // live -> 1
    step(1, 2'd1, DX, 0, 0, 0, 16'h5A5A, "R5");          // rejected
    step(0, 0, 0, 0, 0, 0, 16'h5A5A, "R5");              // pulse gone
    step(1, 2'd0, DD, 0, 0, 0, 16'hC3C3, "R3");
    step(0, 0, 0, 0, 0, 1, 16'h9876, "R6");              // back to 0
    step(0, 0, 0, 0, 0, 1, 16'h9876, "R6");              // back to 1
    step(0, 0, 0, 0, 0, 1, 16'hF0F0, "R6");              // back to 0
    step(0, 0, 0, 1, 2'd2, 0, 16'h0F0F, "R2");           // live -> 2
    step(0, 0, 0, 1, 2'd2, 0, 16'h0F0F, "R8");           // same index
    step(0, 0, 0, 1, 2'd3, 1, 16'h7777, "R8");           // fb wins
    step(1, 2'd3, DE, 1, 2'd3, 0, 16'h3333, "R7");       // clash
    step(0, 0, 0, 1, 2'd1, 1, 16'hABCD, "R10");          // deferred applies
    step(0, 0, 0, 0, 0, 0, 16'hABCD, "R7");
    step(0, 0, 0, 0, 0, 1, 16'h1111, "R6");
    for (int v = 0; v < 16; v++)
      step(0, 0, 0, 0, 0, 0, {4{4'(v)}}, "R9");
    step(0, 0, 0, 1, 2'd3, 0, 16'h0000, "R2");
    for (int v = 0; v < 16; v++)
      step(0, 0, 0, 0, 0, 0, {4'(v), 4'(15-v), 4'(v^5), 4'(v^10)}, "R9");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #2;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule